// File: doc/BRIEF.md
# Outbound PCI Window Enable Decoder

This block decides whether a CPU-side memory address falls into a PCI memory window that software has opened. The top sixteenth of the 32-bit address space (tag nibble 0xF) is split into 32 chunks of 8 MB each. A 32-bit enable mask picks which chunks are forwarded. A two-bit mode field inside a control register gates the whole map. The lowest chunk, which holds firmware, and the highest chunk, which holds the bridge's own registers, can never be forwarded, whatever the mask holds.

Software programs the block through a one-cycle register write port and can read the registers back through a combinational read port. Every request that is presented gets a registered answer one cycle later. The answer is a valid strobe, a hit flag and the unchanged address to use on the PCI side. A write changes the decode for every request presented after the clock edge that took the write.

Top module: `pci_window_decoder`

## Requirements
- R1: After reset the mask, control and back-to-back registers read 0, and no request produces a hit.
- R2: A request hits only when all of these hold: address bits [31:28] are 0xF, control bits [8:7] are 2'b01, and the mask bit selected by the chunk index (address bits [27:23]) is 1. This covers 0xF0800000 through 0xFF7FFFFF.
- R3: Chunk index 0 (0xF0000000–0xF07FFFFF) and chunk index 31 (0xFF800000–0xFFFFFFFF) never hit, even with the corresponding mask bit set.
- R4: When control bits [8:7] hold 2'b00, 2'b10 or 2'b11, no chunk hits. The other control bits have no effect on the decode.
- R5: An address whose bits [31:28] are not 0xF never hits.
- R6: A register write takes effect for a request presented in the cycle after the write. A request presented in the same cycle as the write is decoded with the old register values.
- R7: A write to the back-to-back register (select 2) keeps only data bits [1:0]. Read-back bits [31:2] are 0.
- R8: The fwd_valid output copies req_valid one cycle later. While fwd_valid is 1, fwd_addr equals the request address. The fwd_hit output is never 1 while fwd_valid is 0.
- R9: Select 0 (mask) and select 1 (control) store all 32 written bits and read them back unchanged.
- R10: A write with select 3 changes no register, and select 3 reads as 0.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 mask, 1 control, 2 back-to-back, 3 unused |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | 2 | Read select, same encoding as cfg_sel |
| cfg_rd_data | output | 32 | Combinational read data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | CPU-side address |
| fwd_valid | output | 1 | Answer strobe, one cycle after req_valid |
| fwd_hit | output | 1 | Address is forwarded to PCI |
| fwd_addr | output | 32 | Unchanged address for the PCI side |

## Verification
A wrong map bit or a corrupted mode field can only be seen as a wrong fwd_hit. It appears on the answer one cycle after the first request aimed at the affected chunk. For this reason the random stimulus concentrates addresses inside the 0xF tag range and sweeps mask and mode values, so that every chunk is probed soon after each write. A lost or late write shows up on the very next request, which the same-cycle write-and-request case pins down. Register corruption is also visible at once on the read port.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_FBB  = 2'd2,
    SEL_NONE = 2'd3
  } pwd_sel_e;

  localparam int unsigned TAG_W    = 4;
  localparam logic [3:0]  WIN_TAG  = 4'hF;
  localparam logic [1:0]  MODE_ON  = 2'b01;
  localparam int unsigned FBB_W    = 2;
endpackage

// File: rtl/pwd_regs.sv
module pwd_regs
  import pwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] ctrl_q
);
  logic [FBB_W-1:0] fbb_q;
  logic mask_we, ctrl_we, fbb_we;

  always_comb begin
    mask_we = wr_en && (pwd_sel_e'(wr_sel) == SEL_MASK);
    ctrl_we = wr_en && (pwd_sel_e'(wr_sel) == SEL_CTRL);
    fbb_we  = wr_en && (pwd_sel_e'(wr_sel) == SEL_FBB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctrl_q <= '0;
      fbb_q  <= '0;
    end else begin
      if (mask_we) mask_q <= wr_data;
      if (ctrl_we) ctrl_q <= wr_data;
      if (fbb_we)  fbb_q  <= wr_data[FBB_W-1:0];
    end
  end

  always_comb begin
    unique case (pwd_sel_e'(rd_sel))
      SEL_MASK: rd_data = mask_q;
      SEL_CTRL: rd_data = ctrl_q;
      SEL_FBB:  rd_data = {{(DATA_W-FBB_W){1'b0}}, fbb_q};
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwd_map.sv
module pwd_map
  import pwd_pkg::*;
#(
  parameter int unsigned NCHUNK = 32
) (
  input  logic [NCHUNK-1:0] mask,
  input  logic [1:0]        mode,
  output logic [NCHUNK-1:0] fwd_map,
  output logic              mode_on
);
  // edge chunks (firmware at the bottom, bridge registers at the top) are never opened
  localparam logic [NCHUNK-1:0] KEEP = ~({1'b1, {(NCHUNK-1){1'b0}}} | NCHUNK'(1));

  always_comb begin
    mode_on = (mode == MODE_ON);
    fwd_map = mask & KEEP & {NCHUNK{mode_on}};
  end
endmodule

// File: rtl/pwd_lookup.sv
module pwd_lookup
  import pwd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CHUNK_LG2 = 23,
  localparam int unsigned IDX_W    = ADDR_W - TAG_W - CHUNK_LG2,
  localparam int unsigned NCHUNK   = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NCHUNK-1:0] fwd_map,
  output logic              fwd_valid,
  output logic              fwd_hit,
  output logic [ADDR_W-1:0] fwd_addr
);
  logic             in_win;
  logic [IDX_W-1:0] idx;
  logic             hit_d;

  always_comb begin
    in_win = (req_addr[ADDR_W-1 -: TAG_W] == WIN_TAG);
    idx    = req_addr[CHUNK_LG2 +: IDX_W];
    hit_d  = req_valid && in_win && fwd_map[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_hit   <= 1'b0;
      fwd_addr  <= '0;
    end else begin
      fwd_valid <= req_valid;
      fwd_hit   <= hit_d;
      if (req_valid) fwd_addr <= req_addr;
    end
  end
endmodule

// File: rtl/pci_window_decoder.sv
module pci_window_decoder
  import pwd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CHUNK_LG2  = 23,
  parameter int unsigned MODE_LSB   = 7,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wr_data,
  input  logic [1:0]        cfg_rd_sel,
  output logic [ADDR_W-1:0] cfg_rd_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              fwd_valid,
  output logic              fwd_hit,
  output logic [ADDR_W-1:0] fwd_addr
);
  localparam int unsigned IDX_W  = ADDR_W - TAG_W - CHUNK_LG2;
  localparam int unsigned NCHUNK = 1 << IDX_W;

  // reset: asserted at once, released after SYNC_DEPTH clock edges
  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  rst_n_s;

  genvar g;
  generate
    for (g = 0; g < SYNC_DEPTH; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= (g == 0) ? 1'b1 : sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate
  assign rst_n_s = sync_q[SYNC_DEPTH-1];

  logic [ADDR_W-1:0] mask_q, ctrl_q;
  logic [NCHUNK-1:0] fwd_map;
  logic              mode_on;

  pwd_regs #(.DATA_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (cfg_wr_en),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wr_data),
    .rd_sel  (cfg_rd_sel),
    .rd_data (cfg_rd_data),
    .mask_q  (mask_q),
    .ctrl_q  (ctrl_q)
  );

  pwd_map #(.NCHUNK(NCHUNK)) u_map (
    .mask    (mask_q[NCHUNK-1:0]),
    .mode    (ctrl_q[MODE_LSB +: 2]),
    .fwd_map (fwd_map),
    .mode_on (mode_on)
  );

  pwd_lookup #(.ADDR_W(ADDR_W), .CHUNK_LG2(CHUNK_LG2)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .fwd_map   (fwd_map),
    .fwd_valid (fwd_valid),
    .fwd_hit   (fwd_hit),
    .fwd_addr  (fwd_addr)
  );
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker (
  input logic        clk,
  input logic        rst_n_s,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic [1:0]  cfg_rd_sel,
  input logic [31:0] cfg_rd_data,
  input logic [31:0] ctrl_q,
  input logic        fwd_valid,
  input logic        fwd_hit,
  input logic [31:0] fwd_addr
);
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n_s)
    fwd_hit |-> fwd_valid); // R8
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid |=> fwd_valid); // R8
  AST_ADDR_PASSES: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid |=> (fwd_addr == $past(req_addr))); // R8
  AST_EDGE_CHUNKS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n_s)
    fwd_hit |-> (fwd_addr[27:23] != 5'd0 && fwd_addr[27:23] != 5'd31)); // R3
  AST_TAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n_s)
    fwd_hit |-> (fwd_addr[31:28] == 4'hF)); // R5
  AST_MODE_GATES: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid && (ctrl_q[8:7] != 2'b01) |=> !fwd_hit); // R4
  AST_FBB_NARROW: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_rd_sel == 2'd2) |-> (cfg_rd_data[31:2] == 30'd0)); // R7
  AST_UNUSED_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_rd_sel == 2'd3) |-> (cfg_rd_data == 32'd0)); // R10
endmodule

bind pci_window_decoder pwd_checker u_chk (
  .clk         (clk),
  .rst_n_s     (rst_n_s),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .cfg_rd_sel  (cfg_rd_sel),
  .cfg_rd_data (cfg_rd_data),
  .ctrl_q      (ctrl_q),
  .fwd_valid   (fwd_valid),
  .fwd_hit     (fwd_hit),
  .fwd_addr    (fwd_addr)
);

// File: tb/pci_window_decoder_test.sv
module pci_window_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wr_data = '0;
  logic [1:0]  cfg_rd_sel = 2'd0;
  logic [31:0] cfg_rd_data;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        fwd_valid, fwd_hit;
  logic [31:0] fwd_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] m_mask = '0, m_ctrl = '0;
  logic [1:0]  m_fbb  = '0;

  always #2 clk = ~clk;

  pci_window_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
    .cfg_wr_data(cfg_wr_data), .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
    .req_valid(req_valid), .req_addr(req_addr), .fwd_valid(fwd_valid),
    .fwd_hit(fwd_hit), .fwd_addr(fwd_addr)
  );

  function automatic bit exp_hit(logic [31:0] a, logic [31:0] mk, logic [31:0] ct);
    logic [4:0] ix;
    ix = a[27:23];
    return (a[31:28] == 4'hF) && (ct[8:7] == 2'b01) && (ix != 5'd0) && (ix != 5'd31) && mk[ix];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_wr(logic [1:0] s, logic [31:0] d);
    case (s)
      2'd0: m_mask = d;
      2'd1: m_ctrl = d;
      2'd2: m_fbb  = d[1:0];
      default: ;
    endcase
  endtask

  // drive at negedge, takes effect at next posedge
  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = s; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    model_wr(s, d);
  endtask

  task automatic rd(string tag, logic [1:0] s, logic [31:0] exp);
    @(negedge clk);
    cfg_rd_sel = s;
    #1;
    check(tag, cfg_rd_data, exp);
  endtask

  task automatic req(string tag, logic [31:0] a);
    bit e;
    @(negedge clk);
    e = exp_hit(a, m_mask, m_ctrl);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " hit"}, 32'(fwd_hit), 32'(e));
    check("R8 valid", 32'(fwd_valid), 32'd1);
    check("R8 addr", fwd_addr, a);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd("R1 mask", 2'd0, 32'd0);
    rd("R1 ctrl", 2'd1, 32'd0);
    rd("R1 fbb", 2'd2, 32'd0);
    req("R1", 32'hF0800000);
    req("R1", 32'hF8000000);

    // R9 full-width storage
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'h0000_0080);
    rd("R9 mask", 2'd0, 32'hFFFF_FFFF);
    rd("R9 ctrl", 2'd1, 32'h0000_0080);

    // R2 window bounds, R3 edge chunks, R5 outside tag
    req("R2 low", 32'hF0800000);
    req("R2 high", 32'hFF7FFFFC);
    req("R2 mid", 32'hF7A5_5A54);
    req("R3 chunk0", 32'hF07FFFFC);
    req("R3 chunk31", 32'hFF800000);
    req("R3 top", 32'hFFFFFFFC);
    req("R5 tagE", 32'hE0800000);
    req("R5 low", 32'h0080_0000);

    // R4 mode values
    wr(2'd1, 32'h0000_0180); req("R4 mode3", 32'hF0800000);
    wr(2'd1, 32'h0000_0100); req("R4 mode2", 32'hF0800000);
    wr(2'd1, 32'h0000_0000); req("R4 mode0", 32'hF0800000);
    wr(2'd1, 32'hFFFF_FEFF); req("R4 other bits", 32'hF0800000);
    check("R4 model", 32'(exp_hit(32'hF0800000, m_mask, m_ctrl)), 32'd1);

    // R6 write and request in the same cycle: old values apply
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = 2'd0; cfg_wr_data = 32'd0;
    req_valid = 1'b1; req_addr = 32'hF1000000;
    @(negedge clk);
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    check("R6 same cycle", 32'(fwd_hit), 32'd1);
    model_wr(2'd0, 32'd0);
    req("R6 next", 32'hF1000000);

    // R8 idle cycle
    @(negedge clk);
    check("R8 idle valid", 32'(fwd_valid), 32'd0);
    check("R8 idle hit", 32'(fwd_hit), 32'd0);

    // R7 back-to-back register
    wr(2'd2, 32'hFFFF_FFFF);
    rd("R7 fbb", 2'd2, 32'h0000_0003);
    wr(2'd2, 32'hABCD_0002);
    rd("R7 fbb2", 2'd2, 32'h0000_0002);

    // R10 unused select
    wr(2'd3, 32'h1234_5678);
    rd("R10 mask", 2'd0, m_mask);
    rd("R10 ctrl", 2'd1, m_ctrl);
    rd("R10 fbb", 2'd2, 32'(m_fbb));
    rd("R10 sel3", 2'd3, 32'd0);

    // R2 random sweep with mask and mode changes
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom_range(0, 9);
      if (r == 0) wr(2'd0, $urandom());
      else if (r == 1) begin
        logic [31:0] c;
        c = $urandom();
        if ($urandom_range(0, 3) != 0) c[8:7] = 2'b01;
        wr(2'd1, c);
      end else begin
        logic [31:0] a;
        a = $urandom();
        if ($urandom_range(0, 4) != 0) a[31:28] = 4'hF;
        req("R2 random", a);
      end
    end
    rd("R9 final mask", 2'd0, m_mask);
    rd("R9 final ctrl", 2'd1, m_ctrl);

    done = 1'b1;
    summary();
  end
endmodule